// File: doc/BRIEF.md
# Configurable Redundant-Lane Error Handler

This block sits behind three redundant processing lanes that compute the same word. Each cycle it compares the three results in pairs, votes the majority word onto its output for the next stage, and reports what it found: a data error, a vote that no majority can settle, the lane that was outvoted, and a timing error. The timing error comes from a second capture of the comparison results, taken on a clock that lags the main clock slightly. If the late capture differs from the on-time capture, a comparison was still settling at the edge.

A two-bit mode input is meant to come straight from a field of the instruction word, so the protection level can change from one cycle to the next. In off mode lane A passes through with all flags low. In duplication mode lanes A and B are compared and A is forwarded. In triple mode all three lanes vote. Every sample is handled under the mode presented with it.

The compare trees are three pairwise XOR/OR-reduce units: pair 0 is A/B, pair 1 is B/C and pair 2 is C/A. The vote is classified as one of five outcomes: AGREE, A_OUT, B_OUT, C_OUT or SPLIT. The output stage forwards the word of the lane that outcome selects.

Top module: `ehm_top`

## Requirements
- R1: While rst_n is low, out_word, err_data, err_uncorr, err_timing and bad_lane are all zero.
- R2: With mode 2'b00 (off) or 2'b11 (reserved), out_word equals lane_a one cycle later and err_data, err_uncorr and bad_lane are 0, even when the lanes differ.
- R3: With mode 2'b01 (duplication), out_word equals lane_a one cycle later, err_data is 1 exactly when lane_a differs from lane_b, lane_c has no effect, and err_uncorr and bad_lane are 0.
- R4: With mode 2'b10 (triple) and all three lanes equal, out_word equals lane_a one cycle later and err_data, err_uncorr and bad_lane are 0.
- R5: With mode 2'b10 and exactly one lane differing from the other two, out_word is the value shared by the other two and err_data is 1. err_uncorr is 0, and bad_lane names the outvoted lane (1 = A, 2 = B, 3 = C).
- R6: With mode 2'b10 and all three lanes pairwise different, err_data and err_uncorr are 1, bad_lane is 0 and out_word equals lane_a.
- R7: out_word, err_data, err_uncorr and bad_lane have one cycle of latency. Each sample is handled under its own mode, so a new mode can be applied every cycle.
- R8: err_timing is 1 for exactly one cycle, one cycle after that sample's data flags, when a comparison used by the sample's mode gives a different result at the delayed clock edge than at the main edge. Off and reserved use no comparisons, duplication uses only A/B, and triple uses all three.
- R9: err_timing is 0 for every sample whose comparison results are the same at both edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| clk_dly | input | 1 | Copy of the main clock delayed by a fraction of a period |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 off, 01 duplication, 10 triple, 11 reserved (acts as off) |
| lane_a | input | W | Result word of lane A |
| lane_b | input | W | Result word of lane B |
| lane_c | input | W | Result word of lane C |
| out_word | output | W | Voted or forwarded word |
| err_data | output | 1 | Lanes under comparison disagree |
| err_uncorr | output | 1 | Triple vote found no majority |
| err_timing | output | 1 | On-time and late comparison captures differ |
| bad_lane | output | 2 | Outvoted lane: 0 none, 1 A, 2 B, 3 C |

## Verification
Assertions check on every cycle that off and reserved modes keep the data flags quiet, that duplication never blames a lane, and that an uncorrectable vote and a blamed lane never appear together. They also check that agreeing lanes in triple mode pass lane A through with one cycle of latency, and that a timing flag never follows a sample taken in off mode. Only the bench scenarios show the correct majority word and lane identity for each outvoted lane, and the back-to-back mode changes. They also cover the timing flag itself: lanes changed between the main and delayed edges, with the per-mode masking that decides whether the change counts.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_DWC = 2'b01,
        MODE_TMR = 2'b10,
        MODE_RSV = 2'b11
    } ehm_mode_e;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_A    = 2'd1,
        LANE_B    = 2'd2,
        LANE_C    = 2'd3
    } lane_id_e;

    typedef enum logic [2:0] {
        VOTE_AGREE,
        VOTE_A_OUT,
        VOTE_B_OUT,
        VOTE_C_OUT,
        VOTE_SPLIT
    } vote_e;

    localparam int NUM_LANES = 3;
    localparam int NUM_PAIRS = 3;
    localparam int LANE_IDX_W = $clog2(NUM_LANES);
endpackage

// File: rtl/ehm_compare.sv
module ehm_compare
    import ehm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NUM_LANES-1:0][W-1:0] lanes,
    output logic [NUM_PAIRS-1:0]        eq
);
    // pair p compares lane p against lane (p+1) mod 3: AB, BC, CA
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int OTHER = (p + 1) % NUM_LANES;
        logic [W-1:0] diff;
        assign diff  = lanes[p] ^ lanes[OTHER];
        assign eq[p] = ~|diff;
    end
endmodule

// File: rtl/ehm_voter.sv
module ehm_voter
    import ehm_pkg::*;
(
    input  ehm_mode_e              mode,
    input  logic [NUM_PAIRS-1:0]   eq,
    output logic [LANE_IDX_W-1:0]  sel,
    output logic                   data_err,
    output logic                   uncorr,
    output lane_id_e               blame
);
    vote_e outcome;

    always_comb begin
        unique case (eq)
            3'b111:  outcome = VOTE_AGREE;
            3'b001:  outcome = VOTE_C_OUT;
            3'b010:  outcome = VOTE_A_OUT;
            3'b100:  outcome = VOTE_B_OUT;
            default: outcome = VOTE_SPLIT;
        endcase
    end

    always_comb begin
        sel      = '0;
        data_err = 1'b0;
        uncorr   = 1'b0;
        blame    = LANE_NONE;
        unique case (mode)
            MODE_DWC: data_err = ~eq[0];
            MODE_TMR: begin
                unique case (outcome)
                    VOTE_AGREE: ;
                    VOTE_A_OUT: begin
                        sel      = LANE_IDX_W'(1);
                        data_err = 1'b1;
                        blame    = LANE_A;
                    end
                    VOTE_B_OUT: begin
                        data_err = 1'b1;
                        blame    = LANE_B;
                    end
                    VOTE_C_OUT: begin
                        data_err = 1'b1;
                        blame    = LANE_C;
                    end
                    VOTE_SPLIT: begin
                        data_err = 1'b1;
                        uncorr   = 1'b1;
                    end
                    default: ;
                endcase
            end
            MODE_OFF, MODE_RSV: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/ehm_timing.sv
module ehm_timing
    import ehm_pkg::*;
(
    input  logic                 clk,
    input  logic                 clk_dly,
    input  logic                 rst_n,
    input  logic [NUM_PAIRS-1:0] eq,
    input  ehm_mode_e            mode,
    output logic                 timing_err
);
    logic [NUM_PAIRS-1:0] late_cap;
    logic [NUM_PAIRS-1:0] late_sync;
    logic [NUM_PAIRS-1:0] main_cap;
    logic [NUM_PAIRS-1:0] main_hold;
    logic [NUM_PAIRS-1:0] mask;
    ehm_mode_e            mode_q;
    ehm_mode_e            mode_qq;

    always_ff @(posedge clk_dly or negedge rst_n) begin
        if (!rst_n) late_cap <= '0;
        else        late_cap <= eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_cap  <= '0;
            main_hold <= '0;
            late_sync <= '0;
            mode_q    <= MODE_OFF;
            mode_qq   <= MODE_OFF;
        end else begin
            main_cap  <= eq;
            main_hold <= main_cap;
            late_sync <= late_cap;
            mode_q    <= mode;
            mode_qq   <= mode_q;
        end
    end

    always_comb begin
        unique case (mode_qq)
            MODE_TMR: mask = '1;
            MODE_DWC: mask = NUM_PAIRS'(1);
            MODE_OFF, MODE_RSV: mask = '0;
            default: mask = '0;
        endcase
    end

    assign timing_err = |((main_hold ^ late_sync) & mask);
endmodule

// File: rtl/ehm_top.sv
module ehm_top
    import ehm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clk_dly,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] lane_a,
    input  logic [W-1:0] lane_b,
    input  logic [W-1:0] lane_c,
    output logic [W-1:0] out_word,
    output logic         err_data,
    output logic         err_uncorr,
    output logic         err_timing,
    output logic [1:0]   bad_lane
);
    logic [NUM_LANES-1:0][W-1:0] lanes;
    logic [NUM_PAIRS-1:0]        eq;
    logic [LANE_IDX_W-1:0]       sel;
    logic                        v_err;
    logic                        v_unc;
    lane_id_e                    v_blame;
    ehm_mode_e                   mode_e;

    assign lanes  = {lane_c, lane_b, lane_a};
    assign mode_e = ehm_mode_e'(mode);

    ehm_compare #(.W(W)) cmp_i (.lanes(lanes), .eq(eq));

    ehm_voter vote_i (
        .mode(mode_e), .eq(eq), .sel(sel),
        .data_err(v_err), .uncorr(v_unc), .blame(v_blame)
    );

    ehm_timing tim_i (
        .clk(clk), .clk_dly(clk_dly), .rst_n(rst_n),
        .eq(eq), .mode(mode_e), .timing_err(err_timing)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word   <= '0;
            err_data   <= 1'b0;
            err_uncorr <= 1'b0;
            bad_lane   <= LANE_NONE;
        end else begin
            out_word   <= lanes[sel];
            err_data   <= v_err;
            err_uncorr <= v_unc;
            bad_lane   <= v_blame;
        end
    end

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF || mode == MODE_RSV) |=> (!err_data && !err_uncorr && bad_lane == 2'd0));

    // R3
    dwc_no_blame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DWC) |=> (bad_lane == 2'd0 && !err_uncorr));

    // R7
    pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_TMR) |=> (out_word == $past(lane_a)));

    // R4
    agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TMR && lane_a == lane_b && lane_b == lane_c)
        |=> (out_word == $past(lane_a) && !err_data));

    // R6
    split_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_uncorr |-> (err_data && bad_lane == 2'd0));

    // R5
    blame_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_lane != 2'd0) |-> (err_data && !err_uncorr));

    // R8
    timing_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timing |-> ($past(mode, 2) == MODE_DWC || $past(mode, 2) == MODE_TMR));
endmodule

// File: tb/ehm_top_tb_top.sv
module ehm_top_tb_top;
    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] word;
        logic         data;
        logic         unc;
        logic [1:0]   bad;
    } res_t;

    typedef struct {
        int    due;
        res_t  exp;
        logic  tim;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         clk_dly = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] lane_a = '0, lane_b = '0, lane_c = '0;
    logic [W-1:0] out_word;
    logic         err_data, err_uncorr, err_timing;
    logic [1:0]   bad_lane;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    item_t mq[$];
    item_t tq[$];

    ehm_top #(.W(W)) dut_i (
        .clk(clk), .clk_dly(clk_dly), .rst_n(rst_n), .mode(mode),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c),
        .out_word(out_word), .err_data(err_data), .err_uncorr(err_uncorr),
        .err_timing(err_timing), .bad_lane(bad_lane)
    );

    initial forever #5 clk = ~clk;
    initial begin #2; forever #5 clk_dly = ~clk_dly; end
    always @(posedge clk) cyc <= cyc + 1;

    function automatic res_t model(logic [1:0] m, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        res_t r;
        r = '{word: a, data: 1'b0, unc: 1'b0, bad: 2'd0};
        if (m == 2'b01) r.data = (a != b);
        else if (m == 2'b10) begin
            if (a == b && b == c) r.data = 1'b0;
            else if (b == c) begin r.word = b; r.data = 1'b1; r.bad = 2'd1; end
            else if (a == c) begin r.data = 1'b1; r.bad = 2'd2; end
            else if (a == b) begin r.data = 1'b1; r.bad = 2'd3; end
            else begin r.data = 1'b1; r.unc = 1'b1; end
        end
        return r;
    endfunction

    function automatic logic [2:0] eqv(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        return {c == a, b == c, a == b};
    endfunction

    function automatic logic [2:0] pmask(logic [1:0] m);
        return (m == 2'b10) ? 3'b111 : (m == 2'b01) ? 3'b001 : 3'b000;
    endfunction

    task automatic push(logic [1:0] m, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, logic t, string tag);
        item_t it;
        it.due = cyc + 1; it.exp = model(m, a, b, c); it.tim = 1'b0; it.tag = tag;
        mq.push_back(it);
        it.due = cyc + 2; it.tim = t;
        tq.push_back(it);
    endtask

    task automatic apply(logic [1:0] m, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, string tag);
        @(negedge clk);
        mode = m; lane_a = a; lane_b = b; lane_c = c;
        push(m, a, b, c, 1'b0, tag);
    endtask

    // lanes change between the main edge and the delayed edge
    task automatic glitch(logic [1:0] m, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                          logic [W-1:0] na, logic [W-1:0] nb, logic [W-1:0] nc, string tag);
        @(negedge clk);
        mode = m; lane_a = a; lane_b = b; lane_c = c;
        push(m, a, b, c, |((eqv(a, b, c) ^ eqv(na, nb, nc)) & pmask(m)), tag);
        @(posedge clk);
        #1;
        lane_a = na; lane_b = nb; lane_c = nc;
    endtask

    always @(negedge clk) begin
        while (mq.size() > 0 && mq[0].due == cyc) begin
            item_t it;
            res_t  act;
            it = mq.pop_front();
            act = '{word: out_word, data: err_data, unc: err_uncorr, bad: bad_lane};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: word/data/unc/bad actual %h/%b/%b/%0d expected %h/%b/%b/%0d",
                         it.tag, act.word, act.data, act.unc, act.bad,
                         it.exp.word, it.exp.data, it.exp.unc, it.exp.bad);
            end
        end
        while (tq.size() > 0 && tq[0].due == cyc) begin
            item_t it;
            it = tq.pop_front();
            checks++;
            if (err_timing !== it.tim) begin
                fails++;
                $display("FAIL %s timing: err_timing actual %b expected %b", it.tag, err_timing, it.tim);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_word, err_data, err_uncorr, err_timing, bad_lane} !== '0) begin
            fails++;
            $display("FAIL R1 reset: actual %h expected 0",
                     {out_word, err_data, err_uncorr, err_timing, bad_lane});
        end
        rst_n = 1'b1;

        apply(2'b00, 8'h11, 8'h22, 8'h33, "R2 off lanes differ");
        apply(2'b11, 8'h44, 8'h45, 8'h46, "R2 reserved lanes differ");
        apply(2'b01, 8'h5A, 8'h5A, 8'hFF, "R3 dwc A=B, C ignored");
        apply(2'b01, 8'h5A, 8'h5B, 8'h5A, "R3 dwc A!=B");
        apply(2'b10, 8'h77, 8'h77, 8'h77, "R4 tmr agree");
        apply(2'b10, 8'h01, 8'hC3, 8'hC3, "R5 tmr A outvoted");
        apply(2'b10, 8'hC3, 8'h01, 8'hC3, "R5 tmr B outvoted");
        apply(2'b10, 8'hC3, 8'hC3, 8'h01, "R5 tmr C outvoted");
        apply(2'b10, 8'h10, 8'h20, 8'h30, "R6 tmr split");
        apply(2'b10, 8'hAA, 8'hBB, 8'hCC, "R7 back-to-back tmr");
        apply(2'b00, 8'hAA, 8'hBB, 8'hCC, "R7 back-to-back off");
        apply(2'b01, 8'hAA, 8'hBB, 8'hCC, "R7 back-to-back dwc");
        apply(2'b10, 8'hAA, 8'h99, 8'hAA, "R7 back-to-back tmr B");
        glitch(2'b10, 8'h66, 8'h66, 8'h66, 8'h66, 8'h66, 8'h67, "R8 tmr late C change");
        apply(2'b10, 8'h66, 8'h66, 8'h66, "R9 tmr steady");
        glitch(2'b01, 8'h66, 8'h66, 8'h66, 8'h66, 8'h66, 8'h00, "R8 dwc C change masked");
        glitch(2'b01, 8'h66, 8'h66, 8'h66, 8'h66, 8'h60, 8'h66, "R8 dwc late B change");
        glitch(2'b00, 8'h66, 8'h66, 8'h66, 8'h01, 8'h02, 8'h03, "R8 off change masked");
        glitch(2'b10, 8'h10, 8'h20, 8'h30, 8'h11, 8'h21, 8'h31, "R8 tmr split stays split");
        apply(2'b01, 8'h00, 8'h00, 8'h00, "R9 dwc steady");

        lfsr = 8'h5D;
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] a, b, c;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            a = {6'd0, lfsr[1:0]};
            b = {6'd0, lfsr[3:2]};
            c = {6'd0, lfsr[5:4]};
            apply(lfsr[7:6], a, b, c, "R7 mixed pattern");
        end

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule